// File: doc/BRIEF.md
# Trapping 64-bit Integer Multiplier

This block is a multi-cycle integer multiplier for a 64-bit datapath. A caller pulses `start` with a 7-bit operation code and two 64-bit operands. The block then works for a fixed number of cycles and pulses `done`. It returns a 64-bit result together with an overflow flag. A code outside the supported set is answered at once with an illegal flag. Whatever traps on the overflow flag lives outside this block.

One unsigned 128-bit product engine serves all five operations. It is an iterative shift-add array that retires `STEP_BITS` multiplier bits per cycle, which makes it radix-4 with the defaults. The 32-bit forms sign-extend their operands before entering the engine. The signed upper half needed for the 64-bit overflow test is recovered from the unsigned upper half by subtracting each operand where the other is negative. Overflow is declared when the bits above the kept result do not all repeat its sign bit. The truncated result is returned even when overflow is flagged.

Top module: `imul_trap`

## Requirements
- R1: Code 0x00 multiplies bits 31:0 of both operands as signed numbers and returns bits 31:0 of the product sign-extended to 64 bits, with the overflow flag low.
- R2: Code 0x20 returns bits 63:0 of the product of A and B, with the overflow flag low.
- R3: Code 0x30 returns bits 127:64 of the unsigned 128-bit product of A and B, with the overflow flag low.
- R4: Code 0x40 sign-extends bits 31:0 of both operands and multiplies them. It returns the same sign-extended low 32 bits as R1. The overflow flag is raised unless product bits 63:31 are all zeros or all ones.
- R5: Code 0x60 returns the low 64 product bits. The overflow flag is raised unless either of two cases holds: the upper 64 bits of the signed 128-bit product are all zeros and bit 63 is 0, or those upper bits are all ones and bit 63 is 1.
- R6: Any other code completes without the engine. On the first rising edge after it is accepted, `done` and `illegal` go high, `result` is 0, `ovf` is low, and `busy` never rises.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running operation finishes with its own operands and code, and no extra `done` follows.
- R8: `done` is high for exactly one cycle. `result`, `ovf` and `illegal` change only in the cycle `done` is high, and they hold their values until the next completion.
- R9: For a supported code, `busy` is high from the edge that accepts `start` until `done`. `done` rises on rising edge 64/STEP_BITS+2 after acceptance, counting the accepting edge as edge 1. With the defaults this is edge 34.
- R10: `ovf` is only ever high for codes 0x40 and 0x60, and `illegal` is low after every supported code.
- R11: While reset is held low, `busy`, `done`, `result`, `ovf` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while busy is low |
| func | input | 7 | Operation code, sampled with start |
| op_a | input | 64 | Multiplicand A, sampled with start |
| op_b | input | 64 | Multiplier B, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result of the last completed operation |
| ovf | output | 1 | Overflow of the last completed operation |
| illegal | output | 1 | Last completed request had an unsupported code |

## Verification
The checker assumes that reset is held for at least one clock before the first request. It also assumes that `func`, `op_a` and `op_b` matter only in a cycle where `start` is high and `busy` is low. The bench changes all inputs on the falling edge and deliberately scrambles the operands and code after each accepted request. This shows that nothing outside that sampling window leaks into a result. The bench also raises `start` in the middle of a run, which the checker's latency and single-pulse properties must tolerate. The operand set stays within legal values but sweeps the sign corners: zero, one, minus one, the most negative and most positive values at both 32 and 64 bits, and random pairs.

// File: rtl/imul_pkg.sv
package imul_pkg;

    localparam int unsigned FN_W = 7;

    localparam logic [FN_W-1:0] FN_MUL32  = 7'h00;
    localparam logic [FN_W-1:0] FN_MULLO  = 7'h20;
    localparam logic [FN_W-1:0] FN_MULHU  = 7'h30;
    localparam logic [FN_W-1:0] FN_MUL32V = 7'h40;
    localparam logic [FN_W-1:0] FN_MULV   = 7'h60;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } imul_state_e;

    function automatic logic fn_is_legal(input logic [FN_W-1:0] f);
        return (f == FN_MUL32) || (f == FN_MULLO) || (f == FN_MULHU) ||
               (f == FN_MUL32V) || (f == FN_MULV);
    endfunction

    function automatic logic fn_is_narrow(input logic [FN_W-1:0] f);
        return (f == FN_MUL32) || (f == FN_MUL32V);
    endfunction

endpackage

// File: rtl/imul_step.sv
// One iteration of the unsigned shift-add engine: retires STEP_BITS
// multiplier bits from the bottom of the product register.
module imul_step #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned STEP_BITS = 2
) (
    input  logic [2*XLEN-1:0] prod_i,
    input  logic [XLEN-1:0]   mcand_i,
    output logic [2*XLEN-1:0] prod_o
);
    localparam int unsigned AW = XLEN + STEP_BITS;

    logic [STEP_BITS-1:0] digit;
    logic [AW-1:0]        mcand_ext;
    logic [AW-1:0]        pp [STEP_BITS];
    logic [AW-1:0]        acc;

    assign digit     = prod_i[STEP_BITS-1:0];
    assign mcand_ext = {{STEP_BITS{1'b0}}, mcand_i};

    genvar gi;
    generate
        for (gi = 0; gi < STEP_BITS; gi++) begin : g_pp
            assign pp[gi] = digit[gi] ? (mcand_ext << gi) : '0;
        end
    endgenerate

    always_comb begin
        acc = {{STEP_BITS{1'b0}}, prod_i[2*XLEN-1:XLEN]};
        for (int i = 0; i < STEP_BITS; i++) begin
            acc = acc + pp[i];
        end
    end

    assign prod_o = {acc, prod_i[XLEN-1:STEP_BITS]};

endmodule

// File: rtl/imul_finish.sv
// Result selection and overflow detection from the finished unsigned product.
module imul_finish
    import imul_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [FN_W-1:0]   fn_i,
    input  logic [2*XLEN-1:0] prod_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic [XLEN-1:0]   result_o,
    output logic              ovf_o
);
    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] lo, hi_u, hi_s, lo_narrow;
    logic [HALF:0]   narrow_top;
    logic            narrow_ovf, wide_ovf;

    assign lo   = prod_i[XLEN-1:0];
    assign hi_u = prod_i[2*XLEN-1:XLEN];

    // signed upper half = unsigned upper half minus each operand whose partner is negative
    assign hi_s = hi_u - (a_i[XLEN-1] ? b_i : '0) - (b_i[XLEN-1] ? a_i : '0);

    assign lo_narrow  = {{HALF{lo[HALF-1]}}, lo[HALF-1:0]};
    assign narrow_top = lo[XLEN-1:HALF-1];
    assign narrow_ovf = !((narrow_top == '0) || (narrow_top == '1));
    assign wide_ovf   = !(((hi_s == '0) && !lo[XLEN-1]) || ((hi_s == '1) && lo[XLEN-1]));

    always_comb begin
        result_o = lo;
        ovf_o    = 1'b0;
        case (fn_i)
            FN_MUL32:  result_o = lo_narrow;
            FN_MULHU:  result_o = hi_u;
            FN_MUL32V: begin
                result_o = lo_narrow;
                ovf_o    = narrow_ovf;
            end
            FN_MULV:   ovf_o = wide_ovf;
            default:   result_o = lo;
        endcase
    end

endmodule

// File: rtl/imul_trap.sv
module imul_trap
    import imul_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned STEP_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [6:0]      func,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            ovf,
    output logic            illegal
);
    localparam int unsigned HALF  = XLEN / 2;
    localparam int unsigned STEPS = XLEN / STEP_BITS;
    localparam int unsigned CNT_W = $clog2(STEPS) + 1;
    localparam int unsigned PW    = 2 * XLEN;

    typedef struct packed {
        imul_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [FN_W-1:0]   fn;
        logic [PW-1:0]     prod;
        logic [XLEN-1:0]   mcand;
        logic [XLEN-1:0]   bsave;
        logic [XLEN-1:0]   res;
        logic              flg_ovf;
        logic              flg_ill;
        logic              pulse;
    } imul_regs_t;

    imul_regs_t r_d, r_q;

    logic [PW-1:0]   step_prod;
    logic [XLEN-1:0] fin_res;
    logic            fin_ovf;
    logic [XLEN-1:0] a_eff, b_eff;

    imul_step #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_step (
        .prod_i  (r_q.prod),
        .mcand_i (r_q.mcand),
        .prod_o  (step_prod)
    );

    imul_finish #(.XLEN(XLEN)) u_finish (
        .fn_i     (r_q.fn),
        .prod_i   (r_q.prod),
        .a_i      (r_q.mcand),
        .b_i      (r_q.bsave),
        .result_o (fin_res),
        .ovf_o    (fin_ovf)
    );

    always_comb begin
        if (fn_is_narrow(func)) begin
            a_eff = {{HALF{op_a[HALF-1]}}, op_a[HALF-1:0]};
            b_eff = {{HALF{op_b[HALF-1]}}, op_b[HALF-1:0]};
        end else begin
            a_eff = op_a;
            b_eff = op_b;
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (fn_is_legal(func)) begin
                        r_d.st    = ST_RUN;
                        r_d.cnt   = '0;
                        r_d.fn    = func;
                        r_d.prod  = {{XLEN{1'b0}}, b_eff};
                        r_d.mcand = a_eff;
                        r_d.bsave = b_eff;
                    end else begin
                        r_d.res     = '0;
                        r_d.flg_ovf = 1'b0;
                        r_d.flg_ill = 1'b1;
                        r_d.pulse   = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                r_d.prod = step_prod;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(STEPS - 1)) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.res     = fin_res;
                r_d.flg_ovf = fin_ovf;
                r_d.flg_ill = 1'b0;
                r_d.pulse   = 1'b1;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.pulse;
    assign result  = r_q.res;
    assign ovf     = r_q.flg_ovf;
    assign illegal = r_q.flg_ill;

endmodule

// File: rtl/imul_trap_chk.sv
module imul_trap_chk
    import imul_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned STEP_BITS = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [6:0]      func,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            ovf,
    input logic            illegal
);
    localparam int unsigned STEPS = XLEN / STEP_BITS;
    localparam int unsigned RW    = $clog2(STEPS + 2) + 1;

    logic [RW-1:0]   busy_run_q;
    logic [FN_W-1:0] fn_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run_q <= '0;
            fn_seen_q  <= '0;
        end else begin
            busy_run_q <= busy ? busy_run_q + 1'b1 : '0;
            if (start && !busy) fn_seen_q <= func;
        end
    end

    // R8: completion pulse lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: outputs change only with done
    a_r8_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(result) || !$stable(ovf) || !$stable(illegal)) |-> done);

    // R9: busy run length before a legal completion is fixed
    a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |-> (busy_run_q == RW'(STEPS + 1)));

    // R9: never busy in the completion cycle
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: unsupported code answers without a busy period and with zero result
    a_r6_illegal_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (busy_run_q == '0 && result == '0 && !ovf));

    // R10: overflow only after the checked forms
    a_r10_ovf_checked_only: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (fn_seen_q == FN_MUL32V || fn_seen_q == FN_MULV));

endmodule

bind imul_trap imul_trap_chk #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_imul_trap_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .func    (func),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .ovf     (ovf),
    .illegal (illegal)
);

// File: tb/imul_trap_test.sv
module imul_trap_test;

    localparam int XLEN  = 64;
    localparam int STEPB = 2;
    localparam int STEPS = XLEN / STEPB;
    localparam int LAT   = STEPS + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        busy, done, ovf, illegal;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    imul_trap #(.XLEN(XLEN), .STEP_BITS(STEPB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .result(result), .ovf(ovf), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference using wide arithmetic
    task automatic ref_op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] r, output logic v, output logic il);
        logic signed [63:0]  n32;
        logic signed [127:0] sa, sb, ps;
        logic [127:0]        pu;
        n32 = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
        sa  = {{64{a[63]}}, a};
        sb  = {{64{b[63]}}, b};
        ps  = sa * sb;
        pu  = {64'b0, a} * {64'b0, b};
        r = '0; v = 1'b0; il = 1'b0;
        case (f)
            7'h00: r = {{32{n32[31]}}, n32[31:0]};
            7'h20: r = pu[63:0];
            7'h30: r = pu[127:64];
            7'h40: begin
                r = {{32{n32[31]}}, n32[31:0]};
                v = !((n32[63:31] == '0) || (&n32[63:31]));
            end
            7'h60: begin
                r = ps[63:0];
                v = !((ps[127:63] == '0) || (&ps[127:63]));
            end
            default: il = 1'b1;
        endcase
    endtask

    function automatic string res_tag(input logic [6:0] f);
        case (f)
            7'h00: return "R1";
            7'h20: return "R2";
            7'h30: return "R3";
            7'h40: return "R4";
            7'h60: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b, input bit poke);
        logic [63:0] er;
        logic ev, eil;
        int lat, exp_lat;
        string rt;
        ref_op(f, a, b, er, ev, eil);
        rt = res_tag(f);
        exp_lat = eil ? 1 : LAT;
        @(negedge clk);
        start = 1'b1; func = f; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0; func = 7'($urandom); op_a = {$urandom, $urandom}; op_b = ~a;
        lat = 1;
        while (!done && lat < 200) begin
            chk(busy == (!eil && lat <= STEPS + 1), "R9 busy", 64'(busy), 64'(!eil));
            if (poke && lat == 10) begin
                start = 1'b1; func = 7'h30; op_a = ~a; op_b = b + 64'd3; // R7 pulse while busy
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == exp_lat, eil ? "R6 latency" : "R9 latency", 64'(lat), 64'(exp_lat));
        chk(!busy, "R9 busy at done", 64'(busy), 64'd0);
        chk(result == er, poke ? "R7 result" : rt, result, er);
        if (f == 7'h40 || f == 7'h60)
            chk(ovf == ev, rt, 64'(ovf), 64'(ev));
        else
            chk(ovf == 1'b0, eil ? "R6 ovf" : "R10 ovf", 64'(ovf), 64'd0);
        chk(illegal == eil, eil ? "R6 illegal" : "R10 illegal", 64'(illegal), 64'(eil));
        @(negedge clk);
        chk(!done, "R8 pulse", 64'(done), 64'd0);
        chk(result == er, "R8 hold", result, er);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 190000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<190000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] vals [12];
        logic [6:0]  fns  [5];
        logic [6:0]  bad  [6];
        vals[0]  = 64'h0;                vals[1]  = 64'h1;
        vals[2]  = 64'hffffffffffffffff; vals[3]  = 64'h8000000000000000;
        vals[4]  = 64'h7fffffffffffffff; vals[5]  = 64'h0000000080000000;
        vals[6]  = 64'hffffffff80000000; vals[7]  = 64'h000000007fffffff;
        vals[8]  = 64'h0000000100000000; vals[9]  = 64'h00000000ffffffff;
        vals[10] = 64'h123456789abcdef0; vals[11] = 64'hfedcba9876543210;
        fns[0] = 7'h00; fns[1] = 7'h20; fns[2] = 7'h30; fns[3] = 7'h40; fns[4] = 7'h60;
        bad[0] = 7'h01; bad[1] = 7'h10; bad[2] = 7'h7f; bad[3] = 7'h21; bad[4] = 7'h61; bad[5] = 7'h31;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ovf && !illegal && result == '0, "R11 reset",
            {result[59:0], busy, done, ovf, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int k = 0; k < 5; k++)
                    run_op(fns[k], vals[i], vals[j], 1'b0);

        for (int i = 0; i < 40; i++)
            for (int k = 0; k < 5; k++)
                run_op(fns[k], {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);

        // R6: unsupported codes
        for (int i = 0; i < 6; i++)
            run_op(bad[i], vals[10], vals[11], 1'b0);

        // R7: start while busy is ignored
        run_op(7'h60, vals[3], vals[2], 1'b1);
        run_op(7'h20, vals[10], vals[11], 1'b1);
        begin
            logic [63:0] held;
            held = result;
            // R8: no further done and stable outputs while idle
            for (int c = 0; c < LAT + 4; c++) begin
                @(negedge clk);
                chk(!done && result == held, "R7 no extra done", {63'd0, done}, 64'd0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule